// File: doc/BRIEF.md
# Byte-Lane Register Access Bridge

The bridge sits between host I/O read and write strobes and a small set of 16-bit internal registers. Software on a host with only an 8-bit I/O path can still reach every register. Each word is split into an even byte and an odd byte. Even-byte writes are parked in a one-entry holding register. The matching odd-byte write completes the word, and the bridge then issues it as a single 16-bit internal write. A read through the 8-bit path returns one byte on the low data lanes: the low byte for an even address, and the upper byte moved down for an odd address. When the configuration input selects 16-bit operation and the byte-high-enable line is wired, whole words pass in one cycle and the bridge drives the 16-bit-cycle indication.

The host side is a plain strobe bus. The bridge holds the ready line low while the internal access is under way and releases it once data is available. It stops driving data when the strobe is removed. The internal side is a valid/ready request channel plus a response strobe. A request stays valid with sel, write flag and data held stable until `req_ready` is sampled high. The register file applies back-pressure by holding `req_ready` low. Exactly one `rsp_valid` pulse must follow each accepted read. The bridge is always able to take that pulse, so the response channel has no ready line. A read of a dedicated reset slot produces a one-cycle soft reset pulse and makes no internal access.

Top module: `isa_reg_bridge`

## Requirements
- R1: After reset, `iochrdy_low`, `iocs16_low`, `sd_oe_lo`, `sd_oe_hi`, `req_valid` and `soft_reset_pulse` are all 0.
- R2: In wide mode (`cfg_byte_mode`=0 and `sbhe_present`=1), a read of register slot s (byte address 2s or 2s+1) returns the whole 16-bit word on `sd_rdata`, with both `sd_oe_lo` and `sd_oe_hi` set.
- R3: In byte mode, a read drives only `sd_oe_lo`. Bits 15:8 of `sd_rdata` are 0, and bits 7:0 carry word bits 7:0 for address bit 0 = 0 or word bits 15:8 for address bit 0 = 1. `sd_oe_hi` is never set in byte mode.
- R4: In byte mode, an even-byte write makes no internal request. A following odd-byte write to the same slot issues one write with data {odd byte, held even byte}.
- R5: In byte mode, an odd-byte write is dropped with no internal request when no even byte is held for that slot. A held byte is discarded by any access to a different slot.
- R6: `iochrdy_low` is 1 from the cycle in which an access is recognized until read data is ready or the internal write is accepted. While `req_ready` is 0, the request stays valid and unchanged.
- R7: `iocs16_low` is 1 during an access only in wide mode, and never in byte mode.
- R8: With `sbhe_present`=0, the bridge behaves as in byte mode whatever `cfg_byte_mode` says.
- R9: A read of slot `RST_SLOT` (byte address 8 by default) gives exactly one cycle of `soft_reset_pulse`, makes no internal request, leaves `iocs16_low` at 0, does not drive data, and discards a held byte. A write to that slot has no effect.
- R10: An access is recognized only while `aen_n` is 0. `sd_oe_lo` drops in the cycle after both strobes return high.
- R11: In wide mode, a write issues one internal write carrying all 16 bits of `sd_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte_mode | input | 1 | 1 selects 8-bit accesses (loaded from nonvolatile configuration) |
| sbhe_present | input | 1 | 1 when the byte-high-enable line is wired; 0 forces byte mode |
| aen_n | input | 1 | Address enable, active low, qualifies an I/O access |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| io_addr | input | ADDR_W | Byte address within the window; bit 0 picks the odd byte |
| sd_wdata | input | 16 | Host write data |
| sd_rdata | output | 16 | Host read data |
| sd_oe_lo | output | 1 | Drive enable for data lanes 7:0 |
| sd_oe_hi | output | 1 | Drive enable for data lanes 15:8 |
| iochrdy_low | output | 1 | 1 pulls the host ready line low (wait state) |
| iocs16_low | output | 1 | 1 asserts the 16-bit-cycle indication |
| soft_reset_pulse | output | 1 | One-cycle soft reset request |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal request accepted |
| req_write | output | 1 | 1 write, 0 read |
| req_sel | output | SEL_W | Target register slot |
| req_wdata | output | 16 | Internal write data |
| rsp_valid | input | 1 | Read data valid, one pulse per accepted read |
| rsp_rdata | input | 16 | Internal read data |

## Verification
The assertions assume the host keeps its strobe low until `iochrdy_low` releases. They also assume `cfg_byte_mode` and `sbhe_present` change only between accesses, and that `rsp_valid` pulses only after an accepted read. The bench drives each access as one task that keeps the strobe low until the wait state ends and then leaves one idle cycle. It changes the mode inputs only between those tasks. Its register model answers each accepted read with one response pulse, after a programmable number of back-pressure cycles.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LANES  = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_DONE = 2'd3
  } cyc_state_e;

  typedef struct packed {
    logic hit;
    logic is_rst;
    logic is_read;
    logic odd;
  } cyc_flags_t;
endpackage

// File: rtl/isa_cycle_decode.sv
module isa_cycle_decode
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 3,
  parameter int RST_SLOT = 4,
  parameter int SEL_W    = 2
) (
  input  logic              aen_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [ADDR_W-1:0] io_addr,
  output cyc_flags_t        flags,
  output logic [SEL_W-1:0]  slot_sel
);
  localparam int SLOT_W = ADDR_W - 1;

  logic [SLOT_W-1:0] slot;
  logic              active;
  logic              in_range;
  logic              rst_hit;

  always_comb begin
    slot     = io_addr[ADDR_W-1:1];
    active   = !aen_n && (!ior_n || !iow_n);
    in_range = slot < SLOT_W'(NUM_REGS);
    rst_hit  = slot == SLOT_W'(RST_SLOT);
    flags.hit     = active && (in_range || rst_hit);
    flags.is_rst  = rst_hit;
    flags.is_read = !ior_n;
    flags.odd     = io_addr[0];
    slot_sel      = slot[SEL_W-1:0];
  end
endmodule

// File: rtl/byte_hold.sv
module byte_hold
  import isa_bridge_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [SEL_W-1:0]  load_sel,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              hold_valid,
  output logic [SEL_W-1:0]  hold_sel,
  output logic [BYTE_W-1:0] hold_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_sel   <= '0;
      hold_byte  <= '0;
    end else if (load) begin
      hold_valid <= 1'b1;
      hold_sel   <= load_sel;
      hold_byte  <= load_byte;
    end else if (clear) begin
      hold_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_lane_steer.sv
module rd_lane_steer
  import isa_bridge_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              narrow,
  input  logic              odd,
  input  logic              drive,
  output logic [WORD_W-1:0] lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_low
      assign lanes[BYTE_W-1:0] = !drive ? '0 :
        (narrow && odd) ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
    end else begin : g_up
      assign lanes[(i+1)*BYTE_W-1:i*BYTE_W] = (!drive || narrow) ? '0 :
        word[(i+1)*BYTE_W-1:i*BYTE_W];
    end
  end
endmodule

// File: rtl/isa_cycle_ctrl.sv
module isa_cycle_ctrl
  import isa_bridge_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  cyc_flags_t        flags,
  input  logic [SEL_W-1:0]  slot_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              strobe_idle,
  input  logic              hold_valid,
  input  logic [SEL_W-1:0]  hold_sel,
  input  logic [BYTE_W-1:0] hold_byte,
  output logic              hold_load,
  output logic              hold_clear,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [SEL_W-1:0]  req_sel,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata,
  output logic [WORD_W-1:0] rd_word,
  output logic              drive_rd,
  output logic              cyc_narrow,
  output logic              cyc_odd,
  output logic              iochrdy_low,
  output logic              iocs16_low,
  output logic              soft_reset_pulse
);
  cyc_state_e state;
  logic cyc_rd, cyc_wide, cyc_cs16;
  logic start, same_slot, reg_write, merge_ok;

  always_comb begin
    start      = (state == ST_IDLE) && flags.hit;
    same_slot  = hold_sel == slot_sel;
    reg_write  = start && !flags.is_rst && !flags.is_read;
    hold_load  = reg_write && !wide_mode && !flags.odd;
    merge_ok   = reg_write && !wide_mode && flags.odd && hold_valid && same_slot;
    hold_clear = start && (flags.is_rst || !same_slot || merge_ok ||
                           (wide_mode && !flags.is_read));
    req_valid  = state == ST_REQ;
    iochrdy_low = start || (state == ST_REQ) || (state == ST_RSP);
    iocs16_low  = start ? (wide_mode && !flags.is_rst)
                        : ((state != ST_IDLE) && cyc_cs16);
    drive_rd   = (state == ST_DONE) && cyc_rd;
    cyc_narrow = !cyc_wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      cyc_rd           <= 1'b0;
      cyc_wide         <= 1'b0;
      cyc_cs16         <= 1'b0;
      cyc_odd          <= 1'b0;
      req_write        <= 1'b0;
      req_sel          <= '0;
      req_wdata        <= '0;
      rd_word          <= '0;
      soft_reset_pulse <= 1'b0;
    end else begin
      soft_reset_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cyc_rd   <= flags.is_read && !flags.is_rst;
            cyc_wide <= wide_mode;
            cyc_cs16 <= wide_mode && !flags.is_rst;
            cyc_odd  <= flags.odd;
            req_sel  <= slot_sel;
            if (flags.is_rst) begin
              soft_reset_pulse <= flags.is_read;
              state            <= ST_DONE;
            end else if (flags.is_read) begin
              req_write <= 1'b0;
              state     <= ST_REQ;
            end else if (wide_mode) begin
              req_write <= 1'b1;
              req_wdata <= wdata;
              state     <= ST_REQ;
            end else if (merge_ok) begin
              req_write <= 1'b1;
              req_wdata <= {wdata[BYTE_W-1:0], hold_byte};
              state     <= ST_REQ;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) state <= req_write ? ST_DONE : ST_RSP;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            rd_word <= rsp_rdata;
            state   <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (strobe_idle) begin
            state    <= ST_IDLE;
            cyc_rd   <= 1'b0;
            cyc_cs16 <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_reg_bridge.sv
module isa_reg_bridge
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 3,
  parameter int RST_SLOT = 4,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_byte_mode,
  input  logic              sbhe_present,
  input  logic              aen_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [15:0]       sd_wdata,
  output logic [15:0]       sd_rdata,
  output logic              sd_oe_lo,
  output logic              sd_oe_hi,
  output logic              iochrdy_low,
  output logic              iocs16_low,
  output logic              soft_reset_pulse,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [SEL_W-1:0]  req_sel,
  output logic [15:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_rdata
);
  cyc_flags_t        flags;
  logic [SEL_W-1:0]  slot_sel;
  logic              hold_load, hold_clear, hold_valid;
  logic [SEL_W-1:0]  hold_sel;
  logic [BYTE_W-1:0] hold_byte;
  logic [WORD_W-1:0] rd_word;
  logic              drive_rd, cyc_narrow, cyc_odd;
  logic              wide_mode;

  assign wide_mode = !cfg_byte_mode && sbhe_present;

  isa_cycle_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RST_SLOT(RST_SLOT), .SEL_W(SEL_W)
  ) u_decode (
    .aen_n(aen_n), .ior_n(ior_n), .iow_n(iow_n), .io_addr(io_addr),
    .flags(flags), .slot_sel(slot_sel)
  );

  byte_hold #(.SEL_W(SEL_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .clear(hold_clear),
    .load_sel(slot_sel), .load_byte(sd_wdata[BYTE_W-1:0]),
    .hold_valid(hold_valid), .hold_sel(hold_sel), .hold_byte(hold_byte)
  );

  isa_cycle_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .flags(flags),
    .slot_sel(slot_sel), .wdata(sd_wdata), .strobe_idle(ior_n && iow_n),
    .hold_valid(hold_valid), .hold_sel(hold_sel), .hold_byte(hold_byte),
    .hold_load(hold_load), .hold_clear(hold_clear),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rd_word(rd_word), .drive_rd(drive_rd), .cyc_narrow(cyc_narrow),
    .cyc_odd(cyc_odd), .iochrdy_low(iochrdy_low), .iocs16_low(iocs16_low),
    .soft_reset_pulse(soft_reset_pulse)
  );

  rd_lane_steer u_steer (
    .word(rd_word), .narrow(cyc_narrow), .odd(cyc_odd), .drive(drive_rd),
    .lanes(sd_rdata)
  );

  assign sd_oe_lo = drive_rd;
  assign sd_oe_hi = drive_rd && !cyc_narrow;
endmodule

// File: rtl/isa_reg_bridge_chk.sv
module isa_reg_bridge_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_byte_mode,
  input logic             sbhe_present,
  input logic             ior_n,
  input logic             iow_n,
  input logic             sd_oe_lo,
  input logic             sd_oe_hi,
  input logic             iochrdy_low,
  input logic             iocs16_low,
  input logic             soft_reset_pulse,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [SEL_W-1:0] req_sel,
  input logic [15:0]      req_wdata
);
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) &&
    $stable(req_sel) && $stable(req_wdata));

  a_r6_no_drive_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_lo |-> !iochrdy_low);

  a_r7_cs16_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
    iocs16_low |-> !cfg_byte_mode && sbhe_present);

  a_r3_no_high_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_hi |-> sd_oe_lo && !cfg_byte_mode && sbhe_present);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_pulse |=> !soft_reset_pulse);

  a_r9_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_pulse |-> !iocs16_low && !req_valid && !sd_oe_lo);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    ior_n && iow_n && !iochrdy_low |=> !sd_oe_lo);
endmodule

bind isa_reg_bridge isa_reg_bridge_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode),
  .sbhe_present(sbhe_present), .ior_n(ior_n), .iow_n(iow_n),
  .sd_oe_lo(sd_oe_lo), .sd_oe_hi(sd_oe_hi), .iochrdy_low(iochrdy_low),
  .iocs16_low(iocs16_low), .soft_reset_pulse(soft_reset_pulse),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_sel(req_sel), .req_wdata(req_wdata)
);

// File: tb/isa_reg_bridge_tb.sv
module isa_reg_bridge_tb;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_byte_mode = 1'b0, sbhe_present = 1'b1;
  logic aen_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [15:0] sd_wdata = '0, sd_rdata;
  logic sd_oe_lo, sd_oe_hi, iochrdy_low, iocs16_low, soft_reset_pulse;
  logic req_valid, req_ready = 1'b0, req_write;
  logic [SEL_W-1:0] req_sel;
  logic [15:0] req_wdata, rsp_rdata = '0;
  logic rsp_valid = 1'b0;

  always #10 clk = ~clk;

  isa_reg_bridge u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int stall = 0, stall_cnt = 0;
  int n_acc = 0, n_soft = 0, last_wait = 0;
  bit pend_rsp = 0, done = 0;
  logic [SEL_W-1:0] pend_sel;
  logic [15:0] model [0:2];
  logic [SEL_W+15:0] exp_q [$];

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // register model and scoreboard monitor
  always @(negedge clk) begin
    rsp_valid <= 1'b0;
    if (soft_reset_pulse) n_soft++;
    if (pend_rsp) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= model[pend_sel];
      pend_rsp = 0;
    end
    if (req_valid) begin
      if (stall_cnt < stall) begin
        req_ready <= 1'b0;
        stall_cnt++;
      end else begin
        req_ready <= 1'b1;
        stall_cnt = 0;
        n_acc++;
        if (req_write) begin
          if (exp_q.size() == 0) begin
            check(0, "R4/R5 unexpected internal write", {req_sel, req_wdata}, 0);
          end else begin
            logic [SEL_W+15:0] e;
            e = exp_q.pop_front();
            check({req_sel, req_wdata} == e, "R4/R11 write content",
                  {req_sel, req_wdata}, e);
          end
          model[req_sel] = req_wdata;
        end else begin
          pend_rsp = 1;
          pend_sel = req_sel;
        end
      end
    end else begin
      req_ready <= 1'b0;
      stall_cnt = 0;
    end
  end

  task automatic wait_ready();
    last_wait = 0;
    @(negedge clk);
    while (iochrdy_low && last_wait < 100) begin
      last_wait++;
      @(negedge clk);
    end
  endtask

  task automatic host_read(input logic [ADDR_W-1:0] a, input logic [15:0] exp,
                           input bit exp_lo, input bit exp_hi, input bit exp_cs,
                           input string tag);
    aen_n = 0; io_addr = a; ior_n = 0;
    wait_ready();
    check(sd_oe_lo == exp_lo, {tag, " low lane enable"}, sd_oe_lo, exp_lo);
    check(sd_oe_hi == exp_hi, {tag, " high lane enable"}, sd_oe_hi, exp_hi);
    check(iocs16_low == exp_cs, {tag, " 16-bit indication"}, iocs16_low, exp_cs);
    if (exp_lo) check(sd_rdata == exp, {tag, " read data"}, sd_rdata, exp);
    ior_n = 1; aen_n = 1;
    @(negedge clk);
    check(!sd_oe_lo, "R10 drivers released", sd_oe_lo, 0);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                            input bit expect_wr, input logic [SEL_W+15:0] e);
    if (expect_wr) exp_q.push_back(e);
    aen_n = 0; io_addr = a; iow_n = 0; sd_wdata = d;
    wait_ready();
    iow_n = 1; aen_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    model[0] = 16'h1234; model[1] = 16'hBEEF; model[2] = 16'h0F0F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!iochrdy_low && !iocs16_low, "R1 wait/16-bit idle", {iochrdy_low, iocs16_low}, 0);
    check(!sd_oe_lo && !sd_oe_hi, "R1 drivers idle", {sd_oe_lo, sd_oe_hi}, 0);
    check(!req_valid && !soft_reset_pulse, "R1 request idle", {req_valid, soft_reset_pulse}, 0);

    // R2 R7 R11 wide mode
    host_read(5'd2, 16'hBEEF, 1, 1, 1, "R2 R7 wide read");
    host_write(5'd4, 16'hA5C3, 1, {2'd2, 16'hA5C3});
    check(exp_q.size() == 0, "R11 wide write issued", exp_q.size(), 0);
    host_read(5'd5, 16'hA5C3, 1, 1, 1, "R11 wide readback");

    // R3 byte-mode reads
    cfg_byte_mode = 1;
    host_read(5'd0, 16'h0034, 1, 0, 0, "R3 R7 even byte read");
    host_read(5'd1, 16'h0012, 1, 0, 0, "R3 odd byte read");

    // R4 merge
    begin
      int a0;
      a0 = n_acc;
      host_write(5'd2, 16'h005A, 0, '0);
      check(n_acc == a0, "R4 even byte held", n_acc, a0);
    end
    host_write(5'd3, 16'h00C7, 1, {2'd1, 16'hC75A});
    check(exp_q.size() == 0, "R4 merged write issued", exp_q.size(), 0);
    host_read(5'd3, 16'h00C7, 1, 0, 0, "R4 odd readback");
    host_read(5'd2, 16'h005A, 1, 0, 0, "R4 even readback");

    // R5 dropped odd writes
    begin
      int a0;
      a0 = n_acc;
      host_write(5'd1, 16'h0077, 0, '0);
      check(n_acc == a0, "R5 odd without held byte", n_acc, a0);
      host_write(5'd0, 16'h0011, 0, '0);
      host_read(5'd4, 16'h00C3, 1, 0, 0, "R5 intervening read");
      a0 = n_acc;
      host_write(5'd1, 16'h0022, 0, '0);
      check(n_acc == a0, "R5 held byte discarded", n_acc, a0);
      host_read(5'd1, 16'h0012, 1, 0, 0, "R5 register unchanged");
    end

    // R8 byte-high-enable absent
    cfg_byte_mode = 0; sbhe_present = 0;
    host_read(5'd3, 16'h00C7, 1, 0, 0, "R8 forced byte mode");

    // R6 back-pressure wait states
    sbhe_present = 1; stall = 3;
    host_read(5'd0, 16'h1234, 1, 1, 1, "R6 stalled read");
    check(last_wait == 5, "R6 read wait cycles", last_wait, 5);
    host_write(5'd0, 16'h4321, 1, {2'd0, 16'h4321});
    check(last_wait == 4, "R6 write wait cycles", last_wait, 4);
    stall = 0;

    // R9 reset slot
    begin
      int a0, s0;
      a0 = n_acc; s0 = n_soft;
      host_read(5'd8, 16'h0000, 0, 0, 0, "R9 reset read");
      check(n_soft == s0 + 1, "R9 one soft reset pulse", n_soft, s0 + 1);
      check(n_acc == a0, "R9 no internal request", n_acc, a0);
      host_write(5'd8, 16'hFFFF, 0, '0);
      check(n_soft == s0 + 1 && n_acc == a0, "R9 reset slot write harmless",
            n_soft, s0 + 1);
      cfg_byte_mode = 1;
      host_write(5'd0, 16'h0099, 0, '0);
      host_read(5'd8, 16'h0000, 0, 0, 0, "R9 reset read byte mode");
      a0 = n_acc;
      host_write(5'd1, 16'h0088, 0, '0);
      check(n_acc == a0, "R9 held byte discarded by reset", n_acc, a0);
    end

    // R10 address enable gating
    begin
      int a0, low;
      a0 = n_acc; low = 0;
      aen_n = 1; io_addr = 5'd0; ior_n = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (iochrdy_low) low++;
      end
      ior_n = 1;
      @(negedge clk);
      check(low == 0 && n_acc == a0, "R10 not recognized with AEN high", low, 0);
    end

    check(exp_q.size() == 0, "R4 R11 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule